// File: doc/BRIEF.md
# Enabled-Channel Round-Robin Scan Sequencer

This block chooses which analog input the converter's multiplexer selects in each serial frame. A 16-bit enable mask picks the channels that take part in the scan. On every frame boundary the sequencer moves to the next enabled channel above the current one. After the highest enabled channel it returns to the lowest. Disabled channels are skipped. A parameter gives the device size (4, 8, 12 or 16 inputs), and mask bits at or above that size have no effect.

The multiplexer select runs one frame ahead of the conversion result. The sequencer therefore also keeps a delayed channel tag, so that the result shifted out in a frame carries the number of the channel it was sampled from.

Entering the scan mode restarts the scan at the lowest enabled channel. A counter-reset request has the same effect during a scan. A mask rewritten during a scan does not restart it: the next search begins just above the current position and uses the new mask.

Commands take effect at the frame boundary. A mode-entry or counter-reset pulse seen at any cycle of a frame, up to and including the cycle of the frame-done strobe, is applied at the end of that frame. A mask write updates the mask one cycle after its strobe.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset the mask is all ones, `mux_sel` is 0, `tag_valid` is 0 and `mask_empty` is 0.
- R2: A one-cycle `mask_wr` loads `mask_data` into the mask on the following clock. Bit i set means channel i is scanned. Bit i clear means channel i is skipped.
- R3: Mask bits at index `DEV_CH` and above are ignored. A mask with no set bit below `DEV_CH` raises `mask_empty`. `mux_sel` never reaches `DEV_CH` or above.
- R4: When `mode_enter` is pulsed in frame N, `mux_sel` holds the lowest enabled channel from the cycle after frame N's `frame_done`. `tag_valid` is 0 throughout frame N+1.
- R5: During a scan, each `frame_done` moves `mux_sel` to the next enabled channel in ascending order. After the highest enabled channel it wraps to the lowest.
- R6: At each `frame_done`, `tag_ch` takes the `mux_sel` value of the frame that just ended. Once the scan has started, `tag_valid` is 1 from frame N+2 onward.
- R7: `cnt_reset` during a scan returns `mux_sel` to the lowest enabled channel at the next frame boundary. Before the scan mode has been entered, `cnt_reset` has no effect on `mux_sel`.
- R8: A mask written during a scan does not restart the scan. The next channel is the first channel enabled in the new mask above the current `mux_sel`, wrapping if needed.
- R9: If no channel is enabled, `mux_sel` holds its value across frame boundaries and `mask_empty` is 1.
- R10: `mux_sel` changes only in the cycle after a `frame_done`. Before the first mode entry it stays at 0.
- R11: `mode_enter` during a running scan restarts it at the lowest enabled channel. The tag of the restart frame is marked invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_done | input | 1 | One-cycle strobe at the end of each conversion frame |
| mode_enter | input | 1 | Pulse: enter the scan mode at the end of this frame |
| cnt_reset | input | 1 | Pulse: restart the scan at the lowest enabled channel |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_data | input | 16 | New enable mask, bit i for channel i |
| mux_sel | output | 4 | Channel the multiplexer selects this frame |
| tag_ch | output | 4 | Channel of the result shifted out this frame |
| tag_valid | output | 1 | `tag_ch` belongs to a scan sample |
| mask_empty | output | 1 | No channel below `DEV_CH` is enabled |

## Verification
The bench drives three corner cases. In the first, a sparse mask forces the search to jump over gaps and wrap from the top enabled channel to the bottom one. A design with an off-by-one rotation would repeat a channel or skip the lowest one. In the second, the mask changes while the scan runs, and the bench checks that the next pick is taken from above the current channel in the new mask. A design that restarted there would jump back to the lowest channel instead. In the third, the bench writes a mask that has bits set only above the device size. A design that let those bits count would select a channel that does not exist, or would not raise the empty flag. The bench also covers the one-frame lag of the tag after entry and after a restart, and the cases where the counter-reset request is ignored before the scan begins.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int MASK_W = 16;
  localparam int CH_W   = $clog2(MASK_W);
  typedef logic [MASK_W-1:0] mask_t;
  typedef logic [CH_W-1:0]   chan_t;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/scan_mask_reg.sv
module scan_mask_reg
  import scan_pkg::*;
#(
  parameter int DEV_CH = 16
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  mask_t wdata_i,
  output mask_t eff_mask_o,
  output logic  empty_o
);
  mask_t mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  // Channels beyond the device size are forced out of the scan.
  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    if (i < DEV_CH) begin : g_live
      assign eff_mask_o[i] = mask_q[i];
    end else begin : g_dead
      assign eff_mask_o[i] = 1'b0;
    end
  end

  assign empty_o = ~|eff_mask_o;
endmodule

// File: rtl/scan_next_pick.sv
module scan_next_pick
  import scan_pkg::*;
(
  input  mask_t mask_i,
  input  chan_t start_i,
  output logic  found_o,
  output chan_t pick_o
);
  logic [2*MASK_W-1:0] dbl;
  mask_t               rot;
  chan_t               off;

  // Rotate so that bit 0 of rot is channel start_i, then take the lowest set bit.
  always_comb begin
    dbl = {mask_i, mask_i};
    rot = dbl[start_i +: MASK_W];
    off = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (rot[i]) off = chan_t'(i);
    end
  end

  assign pick_o  = chan_t'(start_i + off);
  assign found_o = |mask_i;
endmodule

// File: rtl/scan_tag_pipe.sv
module scan_tag_pipe
  import scan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  chan_t sel_i,
  input  logic  valid_i,
  output chan_t tag_o,
  output logic  tag_valid_o
);
  chan_t tag_q, tag_d;
  logic  vld_q, vld_d;

  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (adv_i) begin
      tag_d = sel_i;
      vld_d = valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tag_q <= tag_d;
      vld_q <= vld_d;
    end
  end

  assign tag_o       = tag_q;
  assign tag_valid_o = vld_q;
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import scan_pkg::*;
#(
  parameter int DEV_CH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_done,
  input  logic        mode_enter,
  input  logic        cnt_reset,
  input  logic        mask_wr,
  input  logic [15:0] mask_data,
  output logic [3:0]  mux_sel,
  output logic [3:0]  tag_ch,
  output logic        tag_valid,
  output logic        mask_empty
);
  logic  rst_sync_n;
  mask_t eff_mask;
  logic  found;
  chan_t pick, start;

  logic  pend_ent_q, pend_ent_d, pend_crs_q, pend_crs_d;
  logic  active_q, active_d, selv_q, selv_d;
  chan_t sel_q, sel_d;
  logic  ent_w, crs_w, restart_w;

  scan_rst_sync u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_sync_n)
  );

  scan_mask_reg #(.DEV_CH(DEV_CH)) u_mask (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wr_i      (mask_wr),
    .wdata_i   (mask_data),
    .eff_mask_o(eff_mask),
    .empty_o   (mask_empty)
  );

  // A command counts for the frame it arrives in, including the frame_done cycle.
  assign ent_w     = mode_enter | pend_ent_q;
  assign crs_w     = cnt_reset  | pend_crs_q;
  assign restart_w = ent_w | (active_q & crs_w);
  assign start     = restart_w ? chan_t'(0) : chan_t'(sel_q + 1'b1);

  scan_next_pick u_pick (
    .mask_i (eff_mask),
    .start_i(start),
    .found_o(found),
    .pick_o (pick)
  );

  always_comb begin
    pend_ent_d = pend_ent_q | mode_enter;
    pend_crs_d = pend_crs_q | cnt_reset;
    active_d   = active_q;
    selv_d     = selv_q;
    sel_d      = sel_q;
    if (frame_done) begin
      pend_ent_d = 1'b0;
      pend_crs_d = 1'b0;
      if (restart_w) active_d = 1'b1;
      if ((restart_w || active_q) && found) begin
        sel_d  = pick;
        selv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_ent_q <= 1'b0;
      pend_crs_q <= 1'b0;
      active_q   <= 1'b0;
      selv_q     <= 1'b0;
      sel_q      <= '0;
    end else begin
      pend_ent_q <= pend_ent_d;
      pend_crs_q <= pend_crs_d;
      active_q   <= active_d;
      selv_q     <= selv_d;
      sel_q      <= sel_d;
    end
  end

  scan_tag_pipe u_tag (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .adv_i      (frame_done),
    .sel_i      (sel_q),
    .valid_i    (selv_q & ~ent_w),
    .tag_o      (tag_ch),
    .tag_valid_o(tag_valid)
  );

  assign mux_sel = sel_q;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int DEV_CH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_done,
  input logic        mode_enter,
  input logic        mask_wr,
  input logic [15:0] mask_data,
  input logic [3:0]  mux_sel,
  input logic [3:0]  tag_ch,
  input logic        tag_valid,
  input logic        mask_empty
);
  AST_SEL_HOLDS_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(mux_sel));                                    // R10
  AST_TAG_LAGS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> tag_ch == $past(mux_sel));                             // R6
  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mux_sel) < DEV_CH);                                               // R3
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && mask_empty |=> $stable(mux_sel));                       // R9
  AST_ENTRY_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && mode_enter |=> !tag_valid);                             // R4
  AST_HIGH_BITS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr && (mask_data[DEV_CH-1:0] == '0) |=> mask_empty);             // R3
endmodule

bind chan_scan_seq scan_seq_chk #(.DEV_CH(DEV_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frame_done(frame_done),
  .mode_enter(mode_enter),
  .mask_wr   (mask_wr),
  .mask_data (mask_data),
  .mux_sel   (mux_sel),
  .tag_ch    (tag_ch),
  .tag_valid (tag_valid),
  .mask_empty(mask_empty)
);

// File: tb/chan_scan_seq_bench.sv
module chan_scan_seq_bench;
  localparam int DEV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_done = 1'b0, mode_enter = 1'b0, cnt_reset = 1'b0, mask_wr = 1'b0;
  logic [15:0] mask_data = '0;
  logic [3:0]  mux_sel, tag_ch;
  logic        tag_valid, mask_empty;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] sel;
    logic [3:0] tag;
    logic       tv;
    logic       emp;
    string      req;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_mask;
  logic [3:0]  m_sel;
  bit          m_act, m_selv;

  always #10 clk = ~clk;

  chan_scan_seq #(.DEV_CH(DEV)) u_chan_scan_seq (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .mode_enter(mode_enter),
    .cnt_reset(cnt_reset), .mask_wr(mask_wr), .mask_data(mask_data),
    .mux_sel(mux_sel), .tag_ch(tag_ch), .tag_valid(tag_valid), .mask_empty(mask_empty)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] search(input logic [15:0] m, input logic [3:0] st);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] c;
      c = 4'(st + k);
      if (m[c]) return c;
    end
    return st;
  endfunction

  // Driver: one frame with optional commands, pushes the expected outcome.
  task automatic run_frame(input bit ent, input bit crs, input bit wr,
                           input logic [15:0] wd, input string req);
    exp_t e;
    bit restart, found;
    @(negedge clk);
    mode_enter = ent; cnt_reset = crs; mask_wr = wr; mask_data = wd;
    @(negedge clk);
    mode_enter = 0; cnt_reset = 0; mask_wr = 0;
    if (wr) m_mask = wd & 16'((1 << DEV) - 1);
    @(negedge clk);
    restart = ent | (m_act & crs);
    found   = |m_mask;
    e.tag = m_sel;
    e.tv  = m_selv & !ent;
    if ((restart || m_act) && found) begin
      m_sel  = search(m_mask, restart ? 4'd0 : 4'(m_sel + 1));
      m_selv = 1;
    end
    if (restart) m_act = 1;
    e.sel = m_sel; e.emp = !found; e.req = req;
    q.push_back(e);
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
    @(negedge clk);
  endtask

  // Monitor: compares after each frame boundary.
  initial begin
    forever begin
      @(posedge clk);
      if (frame_done) begin
        @(negedge clk);
        if (q.size() == 0) check("queue", 0, 1);
        else begin
          exp_t e;
          e = q.pop_front();
          check({e.req, " mux_sel"},    mux_sel,    e.sel);
          check({e.req, " tag_ch"},     tag_ch,     e.tag);
          check({e.req, " tag_valid"},  tag_valid,  e.tv);
          check({e.req, " mask_empty"}, mask_empty, e.emp);
        end
      end
    end
  end

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    m_mask = 16'((1 << DEV) - 1); m_sel = 0; m_act = 0; m_selv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 mux_sel", mux_sel, 0);
    check("R1 tag_valid", tag_valid, 0);
    check("R1 mask_empty", mask_empty, 0);
    // R10 idle holds, R7 counter reset ignored while idle
    run_frame(0, 0, 0, 0, "R10 idle");
    run_frame(0, 1, 0, 0, "R7 idle reset");
    // R2 mask write of channels 2,5,6, then R4 entry
    run_frame(0, 0, 1, 16'h0064, "R2 write");
    run_frame(1, 0, 0, 0, "R4 entry");
    run_frame(0, 0, 0, 0, "R6 first tag");
    run_frame(0, 0, 0, 0, "R5 step");
    run_frame(0, 0, 0, 0, "R5 wrap");
    run_frame(0, 0, 0, 0, "R5 after wrap");
    // R7 counter reset mid-scan
    run_frame(0, 1, 0, 0, "R7 restart");
    run_frame(0, 0, 0, 0, "R7 continue");
    // R8 live mask change (channels 0,1,9,11) from current position
    run_frame(0, 0, 1, 16'h0A03, "R8 live mask");
    run_frame(0, 0, 0, 0, "R8 next");
    run_frame(0, 0, 0, 0, "R8 wrap");
    // R11 re-entry while scanning
    run_frame(1, 0, 0, 0, "R11 reentry");
    run_frame(0, 0, 0, 0, "R11 after");
    // R3 bits above device size only -> empty, R9 hold
    run_frame(0, 0, 1, 16'hF000, "R3 high bits");
    run_frame(0, 0, 0, 0, "R9 empty hold");
    // R3 full mask: scan covers 0..11 only and wraps
    run_frame(0, 0, 1, 16'hFFFF, "R3 full mask");
    for (int i = 0; i < 14; i++) run_frame(0, 0, 0, 0, "R5 full sweep");
    repeat (4) @(negedge clk);
    check("queue drained", q.size(), 0);
    finish_up();
  end
endmodule